// File: doc/BRIEF.md
# Pulse Hit Finder with Per-Channel Parameter Extraction

This block watches a stream of samples from many detector channels that share one input port in turn. The samples have already been filtered and had their baseline removed, so the block applies no baseline correction of its own. For each channel it finds pulses: stretches of consecutive samples that lie strictly above a programmable threshold.

When a pulse finishes, the block produces one record that describes it. The record carries the channel, the timestamp of the first sample of the pulse, the pulse duration in samples, the largest sample value seen and the summed ADC over the pulse. The pulse state of each channel is kept in small register arrays indexed by channel number, so the channels can arrive in any interleaving.

Records leave through a valid/ready port backed by a small FIFO. Records that find the FIFO full are dropped, and a sticky flag reports the loss. An instance serves 64 channels of 12-bit signed samples by default. The threshold is a non-negative value of 11 bits.

Top module: `hit_finder`

## Requirements
- R1: A channel's pulse begins on its first accepted sample strictly greater than `threshold`, and the record's `hit_start` equals the `in_time` of that sample.
- R2: A pulse ends on the channel's first accepted sample at or below `threshold`, which is not part of the pulse. `hit_len` is the count of above-threshold samples, and the record is offered on the output in the cycle after the clock edge that accepts the ending sample, if no older record is queued.
- R3: `hit_peak` equals the largest sample value of the pulse.
- R4: `hit_sum` equals the sum of the pulse's samples, saturating at 2^SUM_W-1 instead of wrapping.
- R5: When a pulse reaches 2^LEN_W-1 samples, its record is emitted on that sample with `hit_len_sat`=1 and `hit_len`=2^LEN_W-1, and the channel returns to idle. A following above-threshold sample starts a new pulse with its own timestamp. Records that end normally have `hit_len_sat`=0.
- R6: Channels are tracked independently, and `hit_chan` names the channel whose pulse the record describes.
- R7: `hit_valid` is high whenever a record is queued. A record stays stable while `hit_valid` is high and `hit_ready` is low, it is removed on a cycle with both high, and records leave in the order they were produced.
- R8: A record produced while the FIFO is full and not being read is dropped. `overflow` then rises and stays high until reset.
- R9: After reset, `hit_valid` and `overflow` are low and every channel is idle.
- R10: A cycle with `in_valid` low changes no channel state. Its sample adds nothing to any pulse and does not end one.
- R11: An at-or-below-threshold sample on an idle channel produces no record. Negative samples always count as at or below threshold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | A sample is present this cycle |
| in_chan | input | CH_W | Channel of the sample |
| in_time | input | TIME_W | Free-running sample timestamp |
| in_sample | input | SAMP_W | Signed sample, baseline already removed |
| threshold | input | SAMP_W-1 | Non-negative pulse threshold |
| hit_valid | output | 1 | A record is offered |
| hit_ready | input | 1 | Consumer accepts the offered record |
| hit_chan | output | CH_W | Record: channel |
| hit_start | output | TIME_W | Record: timestamp of first pulse sample |
| hit_len | output | LEN_W | Record: pulse duration in samples |
| hit_peak | output | SAMP_W-1 | Record: largest sample |
| hit_sum | output | SUM_W | Record: saturating sample sum |
| hit_len_sat | output | 1 | Record: duration reached its maximum |
| overflow | output | 1 | Sticky flag: a record was dropped |

## Verification
An accepted sample updates its channel's state at the next clock edge. A record that the sample completes is written into the FIFO at that same edge, so it shows on the output one cycle after the sample is presented when the queue is empty, and later by one cycle for each record ahead of it. The bench keeps a model queue that mirrors the FIFO, including the pop decided by `hit_ready` at each edge. It compares the head of that queue with the outputs half a cycle after every edge. Counted drops set the model's overflow expectation in the same cycle the design's flag is due.

// File: rtl/hitf_pkg.sv
package hitf_pkg;

  typedef enum logic {
    CH_IDLE   = 1'b0,
    CH_ACTIVE = 1'b1
  } ch_state_e;

endpackage

// File: rtl/hitf_track.sv
module hitf_track
  import hitf_pkg::*;
#(
  parameter int TIME_W = 32,
  parameter int SAMP_W = 12,
  parameter int LEN_W  = 8,
  parameter int SUM_W  = 24,
  localparam int PK_W  = SAMP_W - 1
) (
  input  logic                     smp_valid,
  input  logic signed [SAMP_W-1:0] smp_value,
  input  logic [TIME_W-1:0]        smp_time,
  input  logic [PK_W-1:0]          thr,
  input  ch_state_e                cur_state,
  input  logic [TIME_W-1:0]        cur_start,
  input  logic [LEN_W-1:0]         cur_len,
  input  logic [PK_W-1:0]          cur_peak,
  input  logic [SUM_W-1:0]         cur_sum,
  output logic                     upd_en,
  output ch_state_e                nxt_state,
  output logic [TIME_W-1:0]        nxt_start,
  output logic [LEN_W-1:0]         nxt_len,
  output logic [PK_W-1:0]          nxt_peak,
  output logic [SUM_W-1:0]         nxt_sum,
  output logic                     rec_emit,
  output logic                     rec_sat,
  output logic [TIME_W-1:0]        rec_start,
  output logic [LEN_W-1:0]         rec_len,
  output logic [PK_W-1:0]          rec_peak,
  output logic [SUM_W-1:0]         rec_sum
);

  localparam logic [LEN_W-1:0] LEN_MAX = {LEN_W{1'b1}};

  logic              above;
  logic              open_hit;
  logic [PK_W-1:0]   mag;
  logic [SUM_W:0]    sum_wide;
  logic [TIME_W-1:0] acc_start;
  logic [LEN_W-1:0]  acc_len;
  logic [PK_W-1:0]   acc_peak;
  logic [SUM_W-1:0]  acc_sum;
  logic              len_full;

  always_comb begin
    above    = smp_value > $signed({1'b0, thr});
    open_hit = (cur_state == CH_ACTIVE);
    mag      = smp_value[PK_W-1:0];
    sum_wide = {1'b0, cur_sum} + {{(SUM_W + 1 - PK_W){1'b0}}, mag};

    if (open_hit) begin
      acc_start = cur_start;
      acc_len   = cur_len + 1'b1;
      acc_peak  = (mag > cur_peak) ? mag : cur_peak;
      acc_sum   = sum_wide[SUM_W] ? {SUM_W{1'b1}} : sum_wide[SUM_W-1:0];
    end else begin
      acc_start = smp_time;
      acc_len   = {{(LEN_W-1){1'b0}}, 1'b1};
      acc_peak  = mag;
      acc_sum   = {{(SUM_W-PK_W){1'b0}}, mag};
    end
    len_full = (acc_len == LEN_MAX);

    upd_en    = smp_valid;
    nxt_state = (above && !len_full) ? CH_ACTIVE : CH_IDLE;
    nxt_start = acc_start;
    nxt_len   = acc_len;
    nxt_peak  = acc_peak;
    nxt_sum   = acc_sum;

    rec_emit  = smp_valid && (above ? len_full : open_hit);
    rec_sat   = above;
    rec_start = above ? acc_start : cur_start;
    rec_len   = above ? acc_len   : cur_len;
    rec_peak  = above ? acc_peak  : cur_peak;
    rec_sum   = above ? acc_sum   : cur_sum;
  end

endmodule

// File: rtl/hitf_chan_regs.sv
module hitf_chan_regs
  import hitf_pkg::*;
#(
  parameter int N_CHAN = 64,
  parameter int CH_W   = 6,
  parameter int TIME_W = 32,
  parameter int LEN_W  = 8,
  parameter int PK_W   = 11,
  parameter int SUM_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CH_W-1:0]   idx,
  input  logic              wr_en,
  input  ch_state_e         wr_state,
  input  logic [TIME_W-1:0] wr_start,
  input  logic [LEN_W-1:0]  wr_len,
  input  logic [PK_W-1:0]   wr_peak,
  input  logic [SUM_W-1:0]  wr_sum,
  output ch_state_e         rd_state,
  output logic [TIME_W-1:0] rd_start,
  output logic [LEN_W-1:0]  rd_len,
  output logic [PK_W-1:0]   rd_peak,
  output logic [SUM_W-1:0]  rd_sum
);

  ch_state_e         state_q [N_CHAN];
  logic [TIME_W-1:0] start_q [N_CHAN];
  logic [LEN_W-1:0]  len_q   [N_CHAN];
  logic [PK_W-1:0]   peak_q  [N_CHAN];
  logic [SUM_W-1:0]  sum_q   [N_CHAN];

  // Only the state bit needs reset; data words are qualified by it.
  genvar g;
  generate
    for (g = 0; g < N_CHAN; g++) begin : g_chan
      logic hit_here;
      assign hit_here = wr_en && (idx == CH_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          state_q[g] <= CH_IDLE;
        end else if (hit_here) begin
          state_q[g] <= wr_state;
        end
      end

      always_ff @(posedge clk) begin
        if (hit_here) begin
          start_q[g] <= wr_start;
          len_q[g]   <= wr_len;
          peak_q[g]  <= wr_peak;
          sum_q[g]   <= wr_sum;
        end
      end
    end
  endgenerate

  always_comb begin
    rd_state = state_q[idx];
    rd_start = start_q[idx];
    rd_len   = len_q[idx];
    rd_peak  = peak_q[idx];
    rd_sum   = sum_q[idx];
  end

endmodule

// File: rtl/hitf_fifo.sv
module hitf_fifo #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              lost
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW:0]       wr_q, rd_q, wr_d, rd_d;
  logic              lost_q, lost_d;
  logic [AW:0]       fill;
  logic              pop, take;

  always_comb begin
    fill   = wr_q - rd_q;
    pop    = (fill != '0) && out_ready;
    take   = push && ((fill != (AW+1)'(DEPTH)) || pop);
    wr_d   = take ? wr_q + 1'b1 : wr_q;
    rd_d   = pop  ? rd_q + 1'b1 : rd_q;
    lost_d = lost_q || (push && !take);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= '0;
      rd_q   <= '0;
      lost_q <= 1'b0;
    end else begin
      wr_q   <= wr_d;
      rd_q   <= rd_d;
      lost_q <= lost_d;
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      mem[wr_q[AW-1:0]] <= push_data;
    end
  end

  assign out_valid = (fill != '0);
  assign out_data  = mem[rd_q[AW-1:0]];
  assign lost      = lost_q;

endmodule

// File: rtl/hit_finder.sv
module hit_finder
  import hitf_pkg::*;
#(
  parameter int N_CHAN     = 64,
  parameter int TIME_W     = 32,
  parameter int SAMP_W     = 12,
  parameter int LEN_W      = 8,
  parameter int SUM_W      = 24,
  parameter int FIFO_DEPTH = 8,
  localparam int CH_W      = (N_CHAN > 1) ? $clog2(N_CHAN) : 1,
  localparam int PK_W      = SAMP_W - 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [CH_W-1:0]          in_chan,
  input  logic [TIME_W-1:0]        in_time,
  input  logic signed [SAMP_W-1:0] in_sample,
  input  logic [PK_W-1:0]          threshold,
  output logic                     hit_valid,
  input  logic                     hit_ready,
  output logic [CH_W-1:0]          hit_chan,
  output logic [TIME_W-1:0]        hit_start,
  output logic [LEN_W-1:0]         hit_len,
  output logic [PK_W-1:0]          hit_peak,
  output logic [SUM_W-1:0]         hit_sum,
  output logic                     hit_len_sat,
  output logic                     overflow
);

  localparam int REC_W = CH_W + TIME_W + LEN_W + PK_W + SUM_W + 1;

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_int_n = rst_pipe[1];

  logic              smp_en;
  ch_state_e         cur_state, nxt_state;
  logic [TIME_W-1:0] cur_start, nxt_start, rec_start;
  logic [LEN_W-1:0]  cur_len, nxt_len, rec_len;
  logic [PK_W-1:0]   cur_peak, nxt_peak, rec_peak;
  logic [SUM_W-1:0]  cur_sum, nxt_sum, rec_sum;
  logic              upd_en, rec_emit, rec_sat;
  logic [REC_W-1:0]  rec_word, out_word;

  assign smp_en = in_valid && rst_int_n;

  hitf_chan_regs #(
    .N_CHAN (N_CHAN),
    .CH_W   (CH_W),
    .TIME_W (TIME_W),
    .LEN_W  (LEN_W),
    .PK_W   (PK_W),
    .SUM_W  (SUM_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .idx      (in_chan),
    .wr_en    (upd_en),
    .wr_state (nxt_state),
    .wr_start (nxt_start),
    .wr_len   (nxt_len),
    .wr_peak  (nxt_peak),
    .wr_sum   (nxt_sum),
    .rd_state (cur_state),
    .rd_start (cur_start),
    .rd_len   (cur_len),
    .rd_peak  (cur_peak),
    .rd_sum   (cur_sum)
  );

  hitf_track #(
    .TIME_W (TIME_W),
    .SAMP_W (SAMP_W),
    .LEN_W  (LEN_W),
    .SUM_W  (SUM_W)
  ) u_track (
    .smp_valid (smp_en),
    .smp_value (in_sample),
    .smp_time  (in_time),
    .thr       (threshold),
    .cur_state (cur_state),
    .cur_start (cur_start),
    .cur_len   (cur_len),
    .cur_peak  (cur_peak),
    .cur_sum   (cur_sum),
    .upd_en    (upd_en),
    .nxt_state (nxt_state),
    .nxt_start (nxt_start),
    .nxt_len   (nxt_len),
    .nxt_peak  (nxt_peak),
    .nxt_sum   (nxt_sum),
    .rec_emit  (rec_emit),
    .rec_sat   (rec_sat),
    .rec_start (rec_start),
    .rec_len   (rec_len),
    .rec_peak  (rec_peak),
    .rec_sum   (rec_sum)
  );

  assign rec_word = {in_chan, rec_start, rec_len, rec_peak, rec_sum, rec_sat};

  hitf_fifo #(
    .DEPTH  (FIFO_DEPTH),
    .DATA_W (REC_W)
  ) u_fifo (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .push      (rec_emit),
    .push_data (rec_word),
    .out_valid (hit_valid),
    .out_ready (hit_ready),
    .out_data  (out_word),
    .lost      (overflow)
  );

  assign {hit_chan, hit_start, hit_len, hit_peak, hit_sum, hit_len_sat} = out_word;

endmodule

// File: rtl/hitf_checker.sv
module hitf_checker #(
  parameter int CH_W   = 6,
  parameter int TIME_W = 32,
  parameter int LEN_W  = 8,
  parameter int PK_W   = 11,
  parameter int SUM_W  = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hit_valid,
  input logic              hit_ready,
  input logic [CH_W-1:0]   hit_chan,
  input logic [TIME_W-1:0] hit_start,
  input logic [LEN_W-1:0]  hit_len,
  input logic [PK_W-1:0]   hit_peak,
  input logic [SUM_W-1:0]  hit_sum,
  input logic              hit_len_sat,
  input logic              overflow
);

  localparam logic [LEN_W-1:0] LEN_MAX = {LEN_W{1'b1}};

  assert_len_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hit_valid |-> (hit_len != '0));

  assert_peak_positive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hit_valid |-> (hit_peak != '0));

  assert_sum_covers_peak_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hit_valid |-> (hit_sum >= SUM_W'(hit_peak)));

  assert_sat_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_valid && hit_len_sat) |-> (hit_len == LEN_MAX));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_valid && !hit_ready) |=> (hit_valid && $stable(hit_chan) && $stable(hit_start)
      && $stable(hit_len) && $stable(hit_peak) && $stable(hit_sum) && $stable(hit_len_sat)));

  assert_overflow_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

endmodule

bind hit_finder hitf_checker #(
  .CH_W   (CH_W),
  .TIME_W (TIME_W),
  .LEN_W  (LEN_W),
  .PK_W   (PK_W),
  .SUM_W  (SUM_W)
) u_hitf_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .hit_valid   (hit_valid),
  .hit_ready   (hit_ready),
  .hit_chan    (hit_chan),
  .hit_start   (hit_start),
  .hit_len     (hit_len),
  .hit_peak    (hit_peak),
  .hit_sum     (hit_sum),
  .hit_len_sat (hit_len_sat),
  .overflow    (overflow)
);

// File: tb/hit_finder_test.sv
module hit_finder_test;

  localparam int NC     = 4;
  localparam int CW     = 2;
  localparam int TW     = 32;
  localparam int SW     = 12;
  localparam int LW     = 4;
  localparam int UW     = 14;
  localparam int DEPTH  = 4;
  localparam int LMAX   = (1 << LW) - 1;
  localparam int SUMMAX = (1 << UW) - 1;

  typedef struct {
    int chan;
    int start;
    int len;
    int peak;
    int sum;
    int sat;
  } rec_t;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 in_valid = 1'b0;
  logic [CW-1:0]        in_chan = '0;
  logic [TW-1:0]        in_time = '0;
  logic signed [SW-1:0] in_sample = '0;
  logic [SW-2:0]        threshold = '0;
  logic                 hit_valid;
  logic                 hit_ready = 1'b0;
  logic [CW-1:0]        hit_chan;
  logic [TW-1:0]        hit_start;
  logic [LW-1:0]        hit_len;
  logic [SW-2:0]        hit_peak;
  logic [UW-1:0]        hit_sum;
  logic                 hit_len_sat;
  logic                 overflow;

  always #4 clk = ~clk;

  hit_finder #(
    .N_CHAN(NC), .TIME_W(TW), .SAMP_W(SW), .LEN_W(LW), .SUM_W(UW), .FIFO_DEPTH(DEPTH)
  ) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_chan(in_chan), .in_time(in_time),
    .in_sample(in_sample), .threshold(threshold), .hit_valid(hit_valid),
    .hit_ready(hit_ready), .hit_chan(hit_chan), .hit_start(hit_start), .hit_len(hit_len),
    .hit_peak(hit_peak), .hit_sum(hit_sum), .hit_len_sat(hit_len_sat), .overflow(overflow)
  );

  int   checks = 0;
  int   failures = 0;
  int   t = 100;
  int   thr = 0;
  bit   m_ovf = 0;
  bit   finished = 0;
  rec_t q[$];
  int   m_act [NC];
  int   m_start [NC];
  int   m_len [NC];
  int   m_peak [NC];
  int   m_sum [NC];

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at t=%0d", req, act, exp, t);
    end
  endtask

  task automatic model_emit(input int c, input int sat);
    rec_t r;
    int   popping;
    r.chan = c; r.start = m_start[c]; r.len = m_len[c];
    r.peak = m_peak[c]; r.sum = m_sum[c]; r.sat = sat;
    popping = 0;
    if (q.size() >= DEPTH) begin
      m_ovf = 1;   // R8: dropped, queue unchanged
    end else begin
      q.push_back(r);
    end
    m_act[c] = 0;
    popping = popping;
  endtask

  // One cycle: check outputs, drive inputs, model the edge.
  task automatic step(input bit v, input int c, input int s, input bit rdy);
    chk("R7 valid", int'(hit_valid), int'(q.size() != 0));
    chk("R8 overflow", int'(overflow), int'(m_ovf));
    if (hit_valid && q.size() != 0) begin
      chk("R6 chan", int'(hit_chan), q[0].chan);
      chk("R1 start", int'(hit_start), q[0].start);
      chk("R2 len", int'(hit_len), q[0].len);
      chk("R3 peak", int'(hit_peak), q[0].peak);
      chk("R4 sum", int'(hit_sum), q[0].sum);
      chk("R5 sat", int'(hit_len_sat), q[0].sat);
    end
    hit_ready = rdy;
    in_valid  = v;
    in_chan   = CW'(c);
    in_sample = SW'(s);
    in_time   = TW'(t);
    threshold = (SW-1)'(thr);
    if (rdy && q.size() != 0) void'(q.pop_front());
    if (v) begin
      if (s > thr) begin
        if (m_act[c] == 0) begin
          m_act[c] = 1; m_start[c] = t; m_len[c] = 1; m_peak[c] = s; m_sum[c] = s;
        end else begin
          m_len[c]++;
          if (s > m_peak[c]) m_peak[c] = s;
          m_sum[c] = (m_sum[c] + s > SUMMAX) ? SUMMAX : m_sum[c] + s;
        end
        if (m_len[c] == LMAX) model_emit(c, 1);
      end else if (m_act[c] != 0) begin
        model_emit(c, 0);
      end
    end
    @(posedge clk);
    @(negedge clk);
    t++;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NC; c++) m_act[c] = 0;
    repeat (3) @(negedge clk);
    chk("R9 reset valid", int'(hit_valid), 0);
    chk("R9 reset overflow", int'(overflow), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 released valid", int'(hit_valid), 0);

    // R11: at-or-below samples, including negatives, on idle channels
    thr = 50;
    for (int c = 0; c < NC; c++) begin
      step(1, c, 50, 1);
      step(1, c, -300, 1);
      step(1, c, 0, 1);
    end
    // R10: invalid cycles carrying large samples do nothing
    step(0, 1, 900, 1);
    step(1, 1, 60, 1);
    step(0, 1, 2000, 1);   // would raise peak and sum if taken
    step(0, 1, -500, 1);   // would end the pulse if taken
    step(1, 1, 70, 1);
    step(1, 1, 10, 1);
    step(0, 1, 10, 1);
    step(0, 1, 10, 1);
    chk("R11 R10 queue drained", q.size(), 0);

    // Sweep: thresholds x channels x lengths up past saturation (R1..R6)
    for (int ti = 0; ti < 3; ti++) begin
      thr = (ti == 0) ? 0 : (ti == 1) ? 100 : 2046;
      for (int c = 0; c < NC; c++) begin
        for (int len = 1; len <= LMAX + 2; len++) begin
          for (int k = 0; k < len; k++)
            step(1, c, thr + 1 + ((k * 37 + c * 11 + len * 5) % (2047 - thr)), 1);
          step(1, c, (len % 2 == 0) ? thr : -len, 1);
        end
      end
    end

    // Interleaved channels with a stalling consumer (R6, R7, R8)
    thr = 200;
    for (int i = 0; i < 600; i++)
      step(1, i % NC, ((i * 53 + (i % NC) * 97) % 640) - 100, (i % 3) != 0);
    for (int i = 0; i < 12; i++) step(0, 0, 0, 1);
    chk("R7 drained", q.size(), 0);

    // Overflow: consumer stalled, six short pulses into a four-deep queue
    thr = 10;
    for (int i = 0; i < 6; i++) begin
      step(1, i % NC, 20 + i, 0);
      step(1, i % NC, 5, 0);
    end
    chk("R8 overflow expected set", int'(m_ovf), 1);
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0);
    for (int i = 0; i < 8; i++) step(0, 0, 0, 1);
    chk("R8 sticky after drain", int'(overflow), 1);
    chk("R7 empty", int'(hit_valid), 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule